// File: doc/BRIEF.md
# Wiper Register and Non-Volatile Write Manager

This block sits behind a serial front end and owns the register state of two digitally set potentiometer channels. Each channel has a live 7-bit wiper code that drives the resistor switch array and a stored initial code that is copied into the live code at power-up. There are also five general-purpose stored bytes and one control register. The control register holds a volatile-select flag, a software shutdown flag and a read-only busy flag.

The front end presents one register access per byte: a write strobe with address and data, a read address with combinational read data, and a one-cycle pulse when the host deselects the device at the end of a frame. Addresses 0 and 1 reach either the live wiper or the stored initial code, depending on the volatile-select flag. Stored writes also update the live wiper at once. They are held as a single pending byte and committed by a self-timed cycle that starts at the end of the frame. The stored bytes are modelled as flops, and the programming time is modelled as a cycle counter.

Top module: `wiper_nv_regs`

## Requirements
- R1: While reset is held and for RECALL_CYCLES cycles after its release, both wiper codes are 40h and `nv_busy` is 1. The control register (address 8) reads 60h during that window and 40h afterwards. Its bit 7 is volatile-select (0 after reset), bit 6 is software-run (1 after reset) and bit 5 is busy.
- R2: When the power-up recall ends, each wiper code equals the stored initial code of its channel.
- R3: With volatile-select 1, a write to address 0 or 1 changes only that channel's wiper (data bits 6:0) in the next cycle. It starts no stored cycle, and the stored initial code is unchanged.
- R4: With volatile-select 0, a write to address 0 or 1 updates the wiper in the next cycle and sets the stored initial code (bit 7 read as 0). A read of address 0 or 1 then returns the stored code and does not alter the wiper.
- R5: Addresses 2 to 6 are stored 8-bit general-purpose bytes that read back what was committed.
- R6: A stored cycle starts only on the frame-end pulse that follows an accepted stored write. `nv_busy` and control bit 5 are then 1 for exactly NV_WRITE_CYCLES cycles, and the byte reads back once the cycle ends.
- R7: While `nv_busy` is 1, every write is ignored, including writes to the wipers, the initial codes, the general-purpose bytes and the control register.
- R8: Both `ch_shutdown` bits are 1 when `shdn_pin_n` is 0 or the software-run bit is 0, and 0 otherwise. The wiper codes are kept through shutdown, and register access stays available.
- R9: Control register bits 4:0 always read 0, and writing bit 5 has no effect.
- R10: Address 7 and addresses 9 to 15 read 0. Writes to them change no state and start no stored cycle.
- R11: When one frame holds several stored writes, only the last one is committed, and the earlier stored target keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| reg_wr | input | 1 | Write strobe for one register byte |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| frame_done | input | 1 | One-cycle pulse when chip select rises |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| shdn_pin_n | input | 1 | Shutdown pin, active low |
| wiper0_code | output | 7 | Live tap code of channel 0 (00h nearest low end) |
| wiper1_code | output | 7 | Live tap code of channel 1 |
| ch_shutdown | output | 2 | Per-channel shutdown: open high end, wiper to low end |
| nv_busy | output | 1 | Recall or stored write cycle in progress |

## Verification
The embedded assertions check several rules on every cycle. Busy may only begin after a frame-end pulse with a pending byte. Neither wiper nor the control flags may move while busy. A low shutdown pin forces both channels off, and the recall leaves each wiper equal to its stored code. The bench scenarios cover what needs a sequence of frames: the exact busy length, routing on the volatile-select flag, and last-write-wins inside one frame. They also cover the values that survive a second reset, and the zero reads of unmapped addresses.

// File: rtl/wiper_nv_regs.sv
module wiper_nv_regs #(
  parameter int CODE_W          = 7,
  parameter int NUM_GP          = 5,
  parameter int NV_WRITE_CYCLES = 200000,
  parameter int RECALL_CYCLES   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              frame_done,
  output logic [7:0]        reg_rdata,
  input  logic              shdn_pin_n,
  output logic [CODE_W-1:0] wiper0_code,
  output logic [CODE_W-1:0] wiper1_code,
  output logic [1:0]        ch_shutdown,
  output logic              nv_busy
);

  localparam int NV_BYTES = 2 + NUM_GP;
  localparam int AW       = $clog2(NV_BYTES);
  localparam int WC_W     = $clog2(NV_WRITE_CYCLES + 1);
  localparam int RC_W     = $clog2(RECALL_CYCLES + 1);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));
  localparam logic [3:0] NV_END   = 4'(NV_BYTES);
  localparam logic [3:0] CTL_ADDR = 4'd8;

  logic [CODE_W-1:0] wiper [2];
  logic [7:0]        nv_mem [NV_BYTES];
  logic              vol_bit, run_bit;
  logic              pend_v;
  logic [AW-1:0]     pend_addr;
  logic [7:0]        pend_data;
  logic [WC_W-1:0]   wcnt;
  logic [RC_W-1:0]   rcnt;

  logic nv_wip, recall, wr_ok;
  logic is_wiper, is_gp, is_ctl, is_nv;

  assign nv_wip   = wcnt != '0;
  assign recall   = rcnt != '0;
  assign nv_busy  = nv_wip | recall;
  assign wr_ok    = reg_wr & ~nv_busy;
  assign is_wiper = reg_addr < 4'd2;
  assign is_gp    = (reg_addr >= 4'd2) && (reg_addr < NV_END);
  assign is_ctl   = reg_addr == CTL_ADDR;
  assign is_nv    = is_gp | (is_wiper & ~vol_bit);

  assign wiper0_code = wiper[0];
  assign wiper1_code = wiper[1];
  assign ch_shutdown = {2{~shdn_pin_n | ~run_bit}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper[0]  <= MID_CODE;
      wiper[1]  <= MID_CODE;
      vol_bit   <= 1'b0;
      run_bit   <= 1'b1;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      wcnt      <= '0;
      rcnt      <= RC_W'(RECALL_CYCLES);
    end else begin
      if (recall) begin
        rcnt <= rcnt - 1'b1;
        if (rcnt == RC_W'(1)) begin
          wiper[0] <= nv_mem[0][CODE_W-1:0];
          wiper[1] <= nv_mem[1][CODE_W-1:0];
        end
      end
      if (nv_wip) begin
        wcnt <= wcnt - 1'b1;
        if (wcnt == WC_W'(1)) pend_v <= 1'b0;
      end else if (frame_done && pend_v && !recall) begin
        wcnt <= WC_W'(NV_WRITE_CYCLES);
      end
      if (wr_ok) begin
        if (is_ctl) begin
          vol_bit <= reg_wdata[7];
          run_bit <= reg_wdata[6];
        end
        if (is_wiper) wiper[reg_addr[0]] <= reg_wdata[CODE_W-1:0];
        if (is_nv) begin
          pend_v    <= 1'b1;
          pend_addr <= reg_addr[AW-1:0];
          pend_data <= is_wiper ? 8'(reg_wdata[CODE_W-1:0]) : reg_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (nv_wip && wcnt == WC_W'(1)) nv_mem[pend_addr] <= pend_data;
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (is_wiper)
      reg_rdata = vol_bit ? 8'(wiper[reg_addr[0]])
                          : 8'(nv_mem[AW'(reg_addr[0])][CODE_W-1:0]);
    else if (is_gp)
      reg_rdata = nv_mem[reg_addr[AW-1:0]];
    else if (is_ctl)
      reg_rdata = {vol_bit, run_bit, nv_busy, 5'b00000};
  end

  a_r2_recall_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recall) |-> (wiper[0] == nv_mem[0][CODE_W-1:0]) && (wiper[1] == nv_mem[1][CODE_W-1:0]));

  a_r6_start_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_wip) |-> $past(frame_done) && $past(pend_v));

  a_r7_wiper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nv_busy) && nv_busy |-> $stable(wiper[0]) && $stable(wiper[1]));

  a_r7_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nv_busy) |-> $stable(vol_bit) && $stable(run_bit));

  a_r8_pin_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_pin_n |-> ch_shutdown == 2'b11);

endmodule

// File: tb/wiper_nv_regs_test.sv
module wiper_nv_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVW = 30;
  localparam int RCL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic frame_done = 1'b0;
  logic shdn_pin_n = 1'b1;
  logic [7:0] reg_rdata;
  logic [6:0] wiper0_code, wiper1_code;
  logic [1:0] ch_shutdown;
  logic nv_busy;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_nv_regs #(.CODE_W(7), .NUM_GP(5), .NV_WRITE_CYCLES(NVW), .RECALL_CYCLES(RCL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_done(frame_done), .reg_rdata(reg_rdata), .shdn_pin_n(shdn_pin_n),
    .wiper0_code(wiper0_code), .wiper1_code(wiper1_code), .ch_shutdown(ch_shutdown),
    .nv_busy(nv_busy));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (nv_busy && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic t_power_up(input logic first, input int w0, input int w1);
    logic [7:0] d; int n;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wiper0 in reset", wiper0_code, 8'h40);
    rst_n = 1'b1;
    check("R1 wiper1 after release", wiper1_code, 8'h40);
    rd(4'd8, d); check("R1 control during recall", d, 8'h60);
    wait_idle(n); check("R1 recall length", n, RCL);
    rd(4'd8, d); check("R1 control after recall", d, 8'h40);
    if (!first) begin
      check("R2 wiper0 recalled", wiper0_code, w0);
      check("R2 wiper1 recalled", wiper1_code, w1);
    end
  endtask

  task automatic t_stored_write();
    logic [7:0] d; int n;
    wr(4'd0, 8'hA3);
    check("R4 wiper0 updated at once", wiper0_code, 8'h23);
    check("R6 no busy before frame end", nv_busy, 0);
    frame();
    rd(4'd8, d); check("R6 busy bit in control", d, 8'h60);
    wait_idle(n); check("R6 stored cycle length", n, NVW);
    rd(4'd0, d); check("R4 initial code read back", d, 8'h23);
    wr(4'd1, 8'h5A); frame(); wait_idle(n);
    rd(4'd1, d); check("R4 initial code ch1", d, 8'h5A);
    check("R4 wiper1 follows", wiper1_code, 8'h5A);
  endtask

  task automatic t_busy_lock();
    logic [7:0] d; int n;
    wr(4'd2, 8'hA5); frame();
    wr(4'd8, 8'hC0); wr(4'd1, 8'h11); wr(4'd3, 8'h77);
    check("R7 wiper1 held while busy", wiper1_code, 8'h5A);
    wait_idle(n);
    rd(4'd8, d); check("R7 control write ignored", d, 8'h40);
    rd(4'd1, d); check("R7 initial code kept", d, 8'h5A);
    rd(4'd2, d); check("R5 general byte 2", d, 8'hA5);
    wr(4'd6, 8'h3C); frame(); wait_idle(n);
    rd(4'd6, d); check("R5 general byte 6", d, 8'h3C);
  endtask

  task automatic t_volatile();
    logic [7:0] d; int n;
    wr(4'd8, 8'hC0);
    wr(4'd0, 8'hFF);
    check("R3 wiper0 volatile write", wiper0_code, 8'h7F);
    rd(4'd0, d); check("R3 read live wiper", d, 8'h7F);
    frame(); check("R3 no stored cycle", nv_busy, 0);
    wr(4'd8, 8'h40);
    rd(4'd0, d); check("R3 initial code unchanged", d, 8'h23);
    wait_idle(n);
    check("R4 read keeps wiper", wiper0_code, 8'h7F);
  endtask

  task automatic t_last_wins();
    logic [7:0] d; int n;
    wr(4'd3, 8'h33); frame(); wait_idle(n);
    wr(4'd3, 8'h44); wr(4'd4, 8'h55); frame(); wait_idle(n);
    rd(4'd3, d); check("R11 first target kept", d, 8'h33);
    rd(4'd4, d); check("R11 last target stored", d, 8'h55);
    wr(4'd0, 8'h10); wr(4'd5, 8'h66); frame(); wait_idle(n);
    check("R11 wiper0 took value", wiper0_code, 8'h10);
    rd(4'd0, d); check("R11 initial code kept", d, 8'h23);
  endtask

  task automatic t_shutdown();
    logic [7:0] d;
    check("R8 running", ch_shutdown, 2'b00);
    @(negedge clk); shdn_pin_n = 1'b0; #1;
    check("R8 pin shutdown", ch_shutdown, 2'b11);
    rd(4'd4, d); check("R8 access in shutdown", d, 8'h55);
    @(negedge clk); shdn_pin_n = 1'b1; #1;
    check("R8 pin release", ch_shutdown, 2'b00);
    wr(4'd8, 8'h00);
    check("R8 soft shutdown", ch_shutdown, 2'b11);
    check("R8 wiper kept", wiper0_code, 8'h10);
    wr(4'd8, 8'h7F);
    rd(4'd8, d); check("R9 busy and low bits not writable", d, 8'h40);
    check("R8 exit restores", ch_shutdown, 2'b00);
    check("R8 wiper1 kept", wiper1_code, 8'h5A);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(4'd7, 8'hFF); wr(4'd9, 8'hFF); wr(4'd15, 8'hC0);
    frame(); check("R10 no stored cycle", nv_busy, 0);
    rd(4'd7, d); check("R10 addr 7 reads zero", d, 0);
    rd(4'd9, d); check("R10 addr 9 reads zero", d, 0);
    rd(4'd15, d); check("R10 addr 15 reads zero", d, 0);
    rd(4'd8, d); check("R10 control untouched", d, 8'h40);
    check("R10 wiper0 untouched", wiper0_code, 8'h10);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_power_up(1'b1, 0, 0);
    t_stored_write();
    t_busy_lock();
    t_volatile();
    t_last_wins();
    t_shutdown();
    t_unmapped();
    wr(4'd8, 8'hC0);
    t_power_up(1'b0, 8'h23, 8'h5A);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule